// File: doc/BRIEF.md
# ADC Conversion-Enable Pulse Generator

This block turns a single-cycle start strobe into one conversion-enable pulse whose length tracks the ADC resolution that has been selected. Two select inputs choose among four resolutions, from 9 to 12 bits. The nominal pulse length starts at a base count for 9 bits and doubles for each extra bit. A ceiling parameter caps the count, so the two finest resolutions both produce the capped length. When the pulse ends, a one-cycle done strobe follows.

The select inputs are decoded inversely: both high gives the coarsest resolution and both low gives the finest. The selects are captured only when a pulse is launched. A start strobe that arrives while a pulse is running has no effect. The block runs from a 40 MHz clock. It has an asynchronous active-low reset whose release is synchronised inside the block, so the first start is accepted two clock cycles after the reset pin rises.

Top module: `cep_pulse_gen`

## Requirements
- R1: While reset is held, and after reset until the first start, `conv_en` and `conv_done` are both 0.
- R2: With `res_sel_b`=1 and `res_sel_a`=1 (9 bits), `conv_en` stays high for exactly BASE_CYCLES (default 256) cycles.
- R3: With `res_sel_b`=1 and `res_sel_a`=0 (10 bits), `conv_en` stays high for exactly 2×BASE_CYCLES (default 512) cycles. This is below the cap and is not shortened.
- R4: With `res_sel_b`=0 and `res_sel_a`=1 (11 bits), the nominal length of 4×BASE_CYCLES (1024) exceeds CAP_CYCLES (default 800). `conv_en` then stays high for exactly CAP_CYCLES cycles. No pulse is ever longer than CAP_CYCLES.
- R5: With `res_sel_b`=0 and `res_sel_a`=0 (12 bits), the nominal length of 8×BASE_CYCLES (2048) is likewise cut to exactly CAP_CYCLES cycles.
- R6: A start strobe that arrives while `conv_en` is high is ignored. The running pulse keeps its length and is not restarted or extended.
- R7: The select inputs are sampled on the cycle the start is accepted. Changing them during a pulse does not alter that pulse, and the new setting applies to the next pulse.
- R8: `conv_done` is high for exactly one cycle: the first cycle in which `conv_en` is low after a pulse. At no other time is it high.
- R9: When `conv_en` is low and `conv_start` is high at a clock edge, `conv_en` is high from that edge onward.
- R10: A start presented during the `conv_done` cycle is accepted, so pulses can run back to back with a single low cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| conv_start | input | 1 | Start strobe, sampled on the rising clock edge |
| res_sel_a | input | 1 | Resolution select, low-order bit (inverted weight) |
| res_sel_b | input | 1 | Resolution select, high-order bit (inverted weight) |
| conv_en | output | 1 | Conversion-enable pulse |
| conv_done | output | 1 | One-cycle strobe following the end of the pulse |

## Verification
The bound checker checks four things on every cycle: the enable rises after an accepted start, the done strobe follows a falling enable and lasts a single cycle, and each pulse length lies between the base count and the cap. These properties cannot tell which resolution was selected, so the exact length for each select pattern is shown only by the bench scenarios. The same holds for the inverted decode order, the ignored mid-pulse start, the mid-pulse select change and back-to-back launches. In each of these the scoreboard compares the measured length against the value it expects.

// File: rtl/cep_pkg.sv
package cep_pkg;
  // Resolution index: extra bits above the coarsest setting
  typedef enum logic [1:0] {
    RES_9B  = 2'd0,
    RES_10B = 2'd1,
    RES_11B = 2'd2,
    RES_12B = 2'd3
  } res_e;

  localparam int unsigned NUM_RES = 4;
endpackage

// File: rtl/cep_rst_sync.sv
module cep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/cep_width_decode.sv
module cep_width_decode
  import cep_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 256,
  parameter int unsigned CAP_CYCLES  = 800,
  parameter int unsigned CNT_W       = 12
) (
  input  logic             sel_a,
  input  logic             sel_b,
  output logic [CNT_W-1:0] width
);
  localparam int unsigned MAX_NOMINAL = BASE_CYCLES << (NUM_RES - 1);

  res_e             res;
  logic [CNT_W-1:0] nominal;

  // Both selects high pick the coarsest resolution: index is the inverse
  always_comb begin
    res     = res_e'(~{sel_b, sel_a});
    nominal = CNT_W'(BASE_CYCLES) << res;
  end

  generate
    if (CAP_CYCLES >= MAX_NOMINAL) begin : g_no_cap
      assign width = nominal;
    end else begin : g_cap
      assign width = (nominal > CNT_W'(CAP_CYCLES)) ? CNT_W'(CAP_CYCLES) : nominal;
    end
  endgenerate
endmodule

// File: rtl/cep_pulse_ctrl.sv
module cep_pulse_ctrl #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             en,
  output logic             done
);
  logic             en_q, en_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // Next-state logic
  always_comb begin
    en_d   = en_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (!en_q) begin
      if (start) begin
        en_d   = 1'b1;
        cnt_d  = load_val - CNT_W'(1);
        cnt_ce = 1'b1;
      end
    end else if (cnt_q == '0) begin
      en_d   = 1'b0;
      done_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_ce = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign en   = en_q;
  assign done = done_q;
endmodule

// File: rtl/cep_pulse_gen.sv
module cep_pulse_gen #(
  parameter int unsigned BASE_CYCLES = 256,
  parameter int unsigned CAP_CYCLES  = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic res_sel_a,
  input  logic res_sel_b,
  output logic conv_en,
  output logic conv_done
);
  localparam int unsigned MAX_NOMINAL = BASE_CYCLES << (cep_pkg::NUM_RES - 1);
  localparam int unsigned MAX_COUNT   = (CAP_CYCLES > MAX_NOMINAL) ? CAP_CYCLES : MAX_NOMINAL;
  localparam int unsigned CNT_W       = $clog2(MAX_COUNT + 1);

  logic             rst_q_n;
  logic [CNT_W-1:0] width;

  cep_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cep_width_decode #(
    .BASE_CYCLES (BASE_CYCLES),
    .CAP_CYCLES  (CAP_CYCLES),
    .CNT_W       (CNT_W)
  ) u_decode (
    .sel_a (res_sel_a),
    .sel_b (res_sel_b),
    .width (width)
  );

  cep_pulse_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (conv_start),
    .load_val (width),
    .en       (conv_en),
    .done     (conv_done)
  );
endmodule

// File: rtl/cep_pulse_gen_chk.sv
module cep_pulse_gen_chk #(
  parameter int unsigned BASE_CYCLES = 256,
  parameter int unsigned CAP_CYCLES  = 800
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic en,
  input logic done
);
  localparam int unsigned RUN_W = $clog2(CAP_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run_len;

  // Length of the current (or just finished) enable pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  run_len <= '0;
    else if (en) run_len <= run_len + RUN_W'(1);
    else         run_len <= '0;
  end

  p_rise_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && start) |=> en);

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!en || $past(en)) && $past(en));

  p_width_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (run_len <= RUN_W'(CAP_CYCLES)));

  p_width_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (run_len >= RUN_W'(BASE_CYCLES)));
endmodule

bind cep_pulse_gen cep_pulse_gen_chk #(
  .BASE_CYCLES (BASE_CYCLES),
  .CAP_CYCLES  (CAP_CYCLES)
) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .start (conv_start),
  .en    (conv_en),
  .done  (conv_done)
);

// File: tb/cep_pulse_gen_tb.sv
`timescale 1ns/1ps
module cep_pulse_gen_tb;
  localparam int CLK_PERIOD = 25;
  localparam int BASE = 256;
  localparam int CAP  = 800;

  logic clk = 1'b0;
  logic rst_n, conv_start, res_sel_a, res_sel_b;
  logic conv_en, conv_done;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit  mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cep_pulse_gen #(.BASE_CYCLES(BASE), .CAP_CYCLES(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .res_sel_a(res_sel_a), .res_sel_b(res_sel_b),
    .conv_en(conv_en), .conv_done(conv_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected length from the requirements: b,a = 11->9b, 10->10b, 01->11b, 00->12b
  function automatic int exp_width(input logic b, input logic a);
    int bits, nom;
    case ({b, a})
      2'b11:   bits = 9;
      2'b10:   bits = 10;
      2'b01:   bits = 11;
      default: bits = 12;
    endcase
    nom = BASE << (bits - 9);
    return (nom < CAP) ? nom : CAP;
  endfunction

  // Driver: launch at a negedge, check the rise (R9), record expectation
  task automatic launch(input logic b, input logic a, input string tag);
    res_sel_b  = b;
    res_sel_a  = a;
    conv_start = 1'b1;
    exp_q.push_back(exp_width(b, a));
    tag_q.push_back(tag);
    @(negedge clk);
    conv_start = 1'b0;
    check("R9 enable rise", int'(conv_en), 1);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: measure each pulse, pop and compare; police the done strobe
  int  run = 0;
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (conv_en) run++;
      if (prev_en && !conv_en) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected pulse", run, 0);
        end else begin
          check(tag_q.pop_front(), run, exp_q.pop_front());
        end
        check("R8 done after fall", int'(conv_done), 1);
        run = 0;
      end else if (conv_done) begin
        check("R8 stray done", int'(conv_done), 0);
      end
      prev_en = conv_en;
    end
  end

  initial begin
    rst_n = 1'b0; conv_start = 1'b0; res_sel_a = 1'b1; res_sel_b = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 en in reset", int'(conv_en), 0);
    check("R1 done in reset", int'(conv_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 en after reset", int'(conv_en), 0);
    check("R1 done after reset", int'(conv_done), 0);
    mon_on = 1'b1;

    launch(1'b1, 1'b1, "R2 9-bit width");  wait_idle();
    launch(1'b1, 1'b0, "R3 10-bit width"); wait_idle();
    launch(1'b0, 1'b1, "R4 11-bit capped"); wait_idle();
    launch(1'b0, 1'b0, "R5 12-bit capped"); wait_idle();

    // R6: second start mid-pulse with another select is ignored
    launch(1'b1, 1'b1, "R6 start ignored");
    repeat (100) @(negedge clk);
    res_sel_b = 1'b0; res_sel_a = 1'b0; conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    wait_idle();

    // R7: select change right after launch affects only the next pulse
    launch(1'b1, 1'b1, "R7 sampled select");
    res_sel_b = 1'b0; res_sel_a = 1'b0;
    wait_idle();
    launch(1'b0, 1'b0, "R7 next pulse uses new select"); wait_idle();

    // R10: start during the done cycle
    launch(1'b1, 1'b0, "R10 first pulse");
    do @(negedge clk); while (!conv_done);
    launch(1'b1, 1'b1, "R10 back-to-back pulse");
    wait_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule